// File: doc/BRIEF.md
# Context Submission Queue Register Block

This block sits between a host register bus and an execution engine. The host builds a list of up to eight 64-bit work descriptors in a pending queue. A descriptor value of zero means the slot is empty. When the list is ready, the host sets the load bit in the control register. The whole queue is then copied into an active set that the engine reads, and a one-cycle `load_valid` pulse goes out. Loading leaves the pending queue intact, so the host must overwrite every slot it wants to change before the next load.

There are two ways to write the queue. A single sequential port takes each descriptor as two dword writes to one address, upper half first. It fills slots 0 through 7 in turn and then wraps to slot 0. A small two-state machine tracks which half comes next: `HALF_UPPER` waits for the upper dword and `HALF_LOWER` waits for the lower one.
- A port write in `HALF_UPPER` latches the upper half and moves to `HALF_LOWER`.
- A port write in `HALF_LOWER` commits the full descriptor to the slot under the pointer, advances the pointer and returns to `HALF_UPPER`.
- Reset forces `HALF_UPPER`.

The second way is an indexed array of dword registers, which lets the host write any slot half directly.

Byte address map: the sequential port is at 0x230. The indexed array runs from 0x510 to 0x54C. The control register is at 0x550, and its bit 0 is the load command. Read data appears on `bus_rdata` in the cycle after `bus_rd`.

Top module: `csq_regblock`

## Requirements
- R1: Reset clears every pending slot and every active slot, holds `load_valid` low, and returns the sequential port to slot 0 and to the `HALF_UPPER` state.
- R2: Slot n is reachable as two indexed dwords. The lower 32 bits are at byte 0x510 + 8n and the upper 32 bits at 0x514 + 8n. A read returns the stored dword in the next cycle.
- R3: On the sequential port (0x230), the first write of a pair is the upper half and changes no visible slot. The second write is the lower half and stores the full descriptor in one step.
- R4: Sequential descriptors fill slots 0, 1, … 7 in order and then wrap to slot 0.
- R5: Writing the pending queue does not change `active_desc` or `active_occupied`.
- R6: A write to 0x550 with bit 0 set copies all pending slots into `active_desc` at once. Slot n occupies bits [64n+63:64n]. `load_valid` is high for exactly the cycle after that write.
- R7: A write to 0x550 with bit 0 clear raises no pulse and leaves the active set unchanged.
- R8: A load leaves the pending slots unchanged.
- R9: Reads of the control register and of the sequential port return zero.
- R10: `active_occupied[n]` is 1 exactly when active slot n is nonzero.
- R11: Writes to addresses outside the port, the array and the control register have no effect, and reads of such addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Byte address, dword aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| load_valid | output | 1 | One-cycle pulse after a load |
| active_desc | output | 512 | Active descriptors, slot n at bits [64n+63:64n] |
| active_occupied | output | 8 | Per-slot nonzero flags of the active set |

## Verification
The assertions assume at most one bus access per cycle: `bus_wr` and `bus_rd` are never high together, and addresses are dword aligned. Under that assumption, a load cycle cannot also write a slot, and a pending-queue write cannot land in the same cycle as a copy. The stimulus meets this by driving every access through tasks that raise one strobe for one cycle on the falling clock edge. The bench also leaves a half-written sequential descriptor pending before a reset, to show that the reset clears the half-toggle.

// File: rtl/csq_pkg.sv
package csq_pkg;
    // half of a descriptor the sequential port expects next
    typedef enum logic {
        HALF_UPPER = 1'b0,
        HALF_LOWER = 1'b1
    } half_state_e;

    localparam int DEF_SLOTS  = 8;
    localparam int DEF_ADDR_W = 12;
    localparam int DEF_DATA_W = 32;
endpackage

// File: rtl/csq_port_fsm.sv
module csq_port_fsm
    import csq_pkg::*;
#(
    parameter int NUM_SLOTS = DEF_SLOTS,
    parameter int DATA_W    = DEF_DATA_W,
    localparam int PTR_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                port_wr,
    input  logic [DATA_W-1:0]   wdata,
    output logic                commit,
    output logic [PTR_W-1:0]    commit_slot,
    output logic [2*DATA_W-1:0] commit_desc
);
    half_state_e         state_q, state_d;
    logic [DATA_W-1:0]   upper_q;
    logic [PTR_W-1:0]    ptr_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HALF_UPPER: if (port_wr) state_d = HALF_LOWER;
            HALF_LOWER: if (port_wr) state_d = HALF_UPPER;
            default:    state_d = HALF_UPPER;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= HALF_UPPER;
            upper_q <= '0;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            if (port_wr && state_q == HALF_UPPER)
                upper_q <= wdata;
            if (commit)
                ptr_q <= (ptr_q == PTR_W'(NUM_SLOTS - 1)) ? '0 : ptr_q + 1'b1;
        end
    end

    always_comb begin
        commit      = port_wr && (state_q == HALF_LOWER);
        commit_slot = ptr_q;
        commit_desc = {upper_q, wdata};
    end
endmodule

// File: rtl/csq_slot_store.sv
module csq_slot_store
    import csq_pkg::*;
#(
    parameter int NUM_SLOTS = DEF_SLOTS,
    parameter int DATA_W    = DEF_DATA_W,
    localparam int PTR_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int IDX_W    = $clog2(2 * NUM_SLOTS)
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                idx_wr,
    input  logic [IDX_W-1:0]                    idx,
    input  logic [DATA_W-1:0]                   wdata,
    input  logic                                commit,
    input  logic [PTR_W-1:0]                    commit_slot,
    input  logic [2*DATA_W-1:0]                 commit_desc,
    output logic [NUM_SLOTS-1:0][2*DATA_W-1:0]  pend
);
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                pend[g] <= '0;
            else if (commit && commit_slot == PTR_W'(g))
                pend[g] <= commit_desc;
            else if (idx_wr && idx == IDX_W'(2 * g))
                pend[g][DATA_W-1:0] <= wdata;
            else if (idx_wr && idx == IDX_W'(2 * g + 1))
                pend[g][2*DATA_W-1:DATA_W] <= wdata;
        end
    end
endmodule

// File: rtl/csq_active_set.sv
module csq_active_set
    import csq_pkg::*;
#(
    parameter int NUM_SLOTS = DEF_SLOTS,
    parameter int DATA_W    = DEF_DATA_W
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                load_cmd,
    input  logic [NUM_SLOTS-1:0][2*DATA_W-1:0]  pend,
    output logic [NUM_SLOTS-1:0][2*DATA_W-1:0]  active,
    output logic                                load_valid
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active     <= '0;
            load_valid <= 1'b0;
        end else begin
            load_valid <= load_cmd;
            if (load_cmd)
                active <= pend;
        end
    end
endmodule

// File: rtl/csq_regblock.sv
module csq_regblock
    import csq_pkg::*;
#(
    parameter int NUM_SLOTS = DEF_SLOTS,
    parameter int ADDR_W    = DEF_ADDR_W,
    parameter int DATA_W    = DEF_DATA_W,
    parameter logic [ADDR_W-1:0] PORT_OFFSET  = 12'h230,
    parameter logic [ADDR_W-1:0] ARRAY_OFFSET = 12'h510,
    parameter logic [ADDR_W-1:0] CTRL_OFFSET  = 12'h550,
    localparam int DESC_W  = 2 * DATA_W,
    localparam int IDX_W   = $clog2(2 * NUM_SLOTS),
    localparam int PTR_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
    localparam int LANE_SH = $clog2(DATA_W / 8),
    localparam int SPAN    = 2 * NUM_SLOTS * (DATA_W / 8)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_wr,
    input  logic                        bus_rd,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [DATA_W-1:0]           bus_wdata,
    output logic [DATA_W-1:0]           bus_rdata,
    output logic                        load_valid,
    output logic [NUM_SLOTS*DESC_W-1:0] active_desc,
    output logic [NUM_SLOTS-1:0]        active_occupied
);
    logic [ADDR_W-1:0]                  rel;
    logic                               arr_hit;
    logic [IDX_W-1:0]                   idx;
    logic                               port_wr, idx_wr, load_cmd;
    logic                               commit;
    logic [PTR_W-1:0]                   commit_slot;
    logic [DESC_W-1:0]                  commit_desc;
    logic [NUM_SLOTS-1:0][DESC_W-1:0]   pend_q;
    logic [NUM_SLOTS-1:0][DESC_W-1:0]   active_q;

    always_comb begin
        rel      = bus_addr - ARRAY_OFFSET;
        arr_hit  = (bus_addr >= ARRAY_OFFSET) && (rel < ADDR_W'(SPAN));
        idx      = IDX_W'(rel >> LANE_SH);
        port_wr  = bus_wr && (bus_addr == PORT_OFFSET);
        idx_wr   = bus_wr && arr_hit;
        load_cmd = bus_wr && (bus_addr == CTRL_OFFSET) && bus_wdata[0];
    end

    csq_port_fsm #(.NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W)) u_port (
        .clk(clk), .rst_n(rst_n), .port_wr(port_wr), .wdata(bus_wdata),
        .commit(commit), .commit_slot(commit_slot), .commit_desc(commit_desc)
    );

    csq_slot_store #(.NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .idx(idx), .wdata(bus_wdata),
        .commit(commit), .commit_slot(commit_slot), .commit_desc(commit_desc),
        .pend(pend_q)
    );

    csq_active_set #(.NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W)) u_active (
        .clk(clk), .rst_n(rst_n), .load_cmd(load_cmd), .pend(pend_q),
        .active(active_q), .load_valid(load_valid)
    );

    // control and port read as zero; only the array returns data
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (bus_rd)
            bus_rdata <= !arr_hit ? '0 :
                         idx[0]   ? pend_q[idx >> 1][DESC_W-1:DATA_W]
                                  : pend_q[idx >> 1][DATA_W-1:0];
    end

    assign active_desc = active_q;
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_occ
        assign active_occupied[g] = |active_q[g];
    end
endmodule

// File: rtl/csq_checker.sv
module csq_checker #(
    parameter int NUM_SLOTS = 8,
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32,
    parameter logic [ADDR_W-1:0] PORT_OFFSET = 12'h230,
    parameter logic [ADDR_W-1:0] CTRL_OFFSET = 12'h550
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             bus_wr,
    input logic                             bus_rd,
    input logic [ADDR_W-1:0]                bus_addr,
    input logic [DATA_W-1:0]                bus_wdata,
    input logic [DATA_W-1:0]                bus_rdata,
    input logic                             load_valid,
    input logic [NUM_SLOTS*2*DATA_W-1:0]    active_desc,
    input logic [NUM_SLOTS*2*DATA_W-1:0]    pend_flat
);
    // R6: a pulse only follows a control write carrying the load bit
    assert_pulse_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load_valid |-> $past(bus_wr && bus_addr == CTRL_OFFSET && bus_wdata[0]));

    // R6: the active set equals the pending queue of the load cycle
    assert_load_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load_valid |-> active_desc == $past(pend_flat));

    // R5: without a load the active set holds
    assert_active_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !load_valid |-> $stable(active_desc));

    // R7: control write with load bit clear gives no pulse
    assert_no_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == CTRL_OFFSET && !bus_wdata[0]) |=> !load_valid);

    // R8: loading leaves the pending queue unchanged
    assert_keep_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load_valid |-> pend_flat == $past(pend_flat));

    // R9: control and port read back as zero
    assert_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (bus_addr == CTRL_OFFSET || bus_addr == PORT_OFFSET)) |=> bus_rdata == '0);
endmodule

bind csq_regblock csq_checker #(
    .NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .PORT_OFFSET(PORT_OFFSET), .CTRL_OFFSET(CTRL_OFFSET)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .load_valid(load_valid), .active_desc(active_desc), .pend_flat(pend_q)
);

// File: tb/sim_csq_regblock.sv
module sim_csq_regblock;
    localparam int  SLOTS = 8;
    localparam time CLK_P = 20ns;
    localparam logic [11:0] PORT = 12'h230, BASE = 12'h510, CTRL = 12'h550;

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [31:0] data;   // write data, or expected read data
    } vec_t;

    // R2 indexed access, R9 control read, R11 unmapped access
    localparam vec_t VEC [14] = '{
        '{1'b1, 12'h510, 32'h1111_0000},
        '{1'b1, 12'h514, 32'h1111_0001},
        '{1'b1, 12'h548, 32'h7777_0000},
        '{1'b1, 12'h54C, 32'h7777_0007},
        '{1'b1, 12'h600, 32'hDEAD_BEEF},
        '{1'b1, 12'h508, 32'hDEAD_BEEF},
        '{1'b0, 12'h510, 32'h1111_0000},
        '{1'b0, 12'h514, 32'h1111_0001},
        '{1'b0, 12'h548, 32'h7777_0000},
        '{1'b0, 12'h54C, 32'h7777_0007},
        '{1'b0, 12'h520, 32'h0000_0000},
        '{1'b0, 12'h550, 32'h0000_0000},
        '{1'b0, 12'h600, 32'h0000_0000},
        '{1'b0, 12'h508, 32'h0000_0000}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic load_valid;
    logic [SLOTS*64-1:0] active_desc;
    logic [SLOTS-1:0] active_occupied;
    int checks = 0, errors = 0;

    always #(CLK_P/2) clk = ~clk;

    csq_regblock u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .load_valid(load_valid), .active_desc(active_desc),
        .active_occupied(active_occupied)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk); bus_rd = 1'b1; bus_addr = a;
        @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
    endtask

    task automatic rd_slot(input int n, output logic [63:0] d);
        logic [31:0] lo, hi;
        rd(BASE + 12'(8 * n), lo);
        rd(BASE + 12'(8 * n + 4), hi);
        d = {hi, lo};
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    function automatic logic [63:0] dsc(input int k);
        return {32'hA000_0000 | 32'(k), 32'h0000_B000 | 32'(k)};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic [63:0] s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 load_valid", 64'(load_valid), 64'd0);
        check("R1 active", 64'(|active_desc), 64'd0);
        for (int n = 0; n < SLOTS; n++) begin
            rd_slot(n, s);
            check("R1 pending slot", s, 64'd0);
        end

        // table walk: R2, R9, R11
        for (int i = 0; i < 14; i++) begin
            if (VEC[i].wr) wr(VEC[i].addr, VEC[i].data);
            else begin
                rd(VEC[i].addr, r);
                check("R2/R9/R11 table read", 64'(r), 64'(VEC[i].data));
            end
        end
        rd(PORT, r);
        check("R9 port read", 64'(r), 64'd0);
        check("R5 active before load", 64'(|active_desc), 64'd0);

        // R7 control write without load bit
        wr(CTRL, 32'hFFFF_FFFE);
        check("R7 no pulse", 64'(load_valid), 64'd0);
        @(negedge clk);
        check("R7 no pulse later", 64'(load_valid), 64'd0);
        check("R7 active unchanged", 64'(|active_desc), 64'd0);

        // R6 load
        wr(CTRL, 32'h1);
        check("R6 pulse", 64'(load_valid), 64'd1);
        check("R6 slot0", active_desc[0 +: 64], 64'h1111_0001_1111_0000);
        check("R6 slot7", active_desc[7*64 +: 64], 64'h7777_0007_7777_0000);
        check("R6 slot2", active_desc[2*64 +: 64], 64'd0);
        check("R10 occupied", 64'(active_occupied), 64'h81);
        @(negedge clk);
        check("R6 one-cycle pulse", 64'(load_valid), 64'd0);
        rd_slot(0, s);
        check("R8 pending kept slot0", s, 64'h1111_0001_1111_0000);
        rd_slot(7, s);
        check("R8 pending kept slot7", s, 64'h7777_0007_7777_0000);

        // R5 pending write does not reach active
        wr(BASE, 32'h5555_5555);
        check("R5 active hold", active_desc[0 +: 64], 64'h1111_0001_1111_0000);

        // dangling upper half, then reset: R1 clears toggle/pointer
        wr(PORT, 32'hFFFF_FFFF);
        do_reset();
        check("R1 active after reset", 64'(|active_desc), 64'd0);

        // R3 half writes
        wr(PORT, dsc(0)[63:32]);
        rd_slot(0, s);
        check("R3 upper alone invisible", s, 64'd0);
        wr(PORT, dsc(0)[31:0]);
        rd_slot(0, s);
        check("R3 full descriptor", s, dsc(0));

        // R4 sequential fill and wrap
        for (int k = 1; k < 9; k++) begin
            wr(PORT, dsc(k)[63:32]);
            wr(PORT, dsc(k)[31:0]);
        end
        for (int n = 1; n < SLOTS; n++) begin
            rd_slot(n, s);
            check("R4 sequential slot", s, dsc(n));
        end
        rd_slot(0, s);
        check("R4 wrap to slot0", s, dsc(8));

        // R10 empty slot after zeroing slot 3
        wr(BASE + 12'h18, 32'h0);
        wr(BASE + 12'h1C, 32'h0);
        wr(CTRL, 32'h1);
        check("R10 occupied mask", 64'(active_occupied), 64'hF7);
        check("R6 slot3 zero", active_desc[3*64 +: 64], 64'd0);
        check("R6 slot5", active_desc[5*64 +: 64], dsc(5));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule